// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one external bus cycle at a time for a 16-bit processor whose address and data share one set of pins. A requester presents a 20-bit address together with direction, memory/I-O space, byte/word width, a cycle kind, a segment tag and write data. The sequencer walks through the states T1, T2, T3, optional wait states Tw and T4. It drives the shared low lines with the address in T1 and with write data afterwards, the upper four shared lines with the high address bits in T1 and with status afterwards, plus the address-latch strobe, the upper-byte enable, the data-enable strobe, the transmit/receive direction and a three-bit cycle status code. For reads it returns the captured data word with a one-cycle done pulse.

The states are ST_IDLE, ST_T1, ST_T2, ST_T3, ST_TW and ST_T4. The transitions are: ST_IDLE to ST_T1 when an aligned request is pending (otherwise stay); ST_T1 to ST_T2; ST_T2 to ST_T3; ST_T3 or ST_TW to ST_T4 when `ready` is high at the clock edge, or to ST_TW when it is low; ST_T4 to ST_T1 when another aligned request is pending, or to ST_IDLE. A request is consumed (`req_accept` high) in any ST_IDLE or ST_T4 cycle in which `req_valid` is high; the requester holds its fields stable until then. The status code of a pending request appears one state ahead, during that ST_IDLE or ST_T4 cycle.

A word request at an odd address is refused: it is consumed with `req_err` high and no bus cycle is run; breaking it into two byte cycles is the requester's job. Write data is expected on its final byte lane already, and read data is returned as the raw 16-bit bus word.

Top module: `mbus_cycle_seq`

## Requirements
- R1: Out of reset and while idle: `ale`=0, `den_n`=1, `bhe_n`=1, `ad_oe`=0, `as_out`=0, `done`=0, `stat`=3'b111 unless a request is pending.
- R2: An accepted aligned request produces exactly one T1 cycle, the cycle after acceptance, with `ale`=1, `ad_oe`=1, `ad_out`=address bits 15..0 and `as_out`=address bits 19..16, or 0 when `req_io`=1.
- R3: From T2 through T4, `as_out` = {1'b0, `int_en` of the current cycle, segment tag[1:0]} (bit 3 down to bit 0).
- R4: `bhe_n` is low only in T1, and there it is low exactly when the access is a word or the address is odd (bit 0 = 1).
- R5: With `ready` high at the end of T3, `done` is high in the fourth cycle after T1 begins; each clock edge in T3/Tw that sees `ready` low inserts one Tw and delays `done` by one cycle. `done` lasts one cycle.
- R6: For writes, `ad_oe`=1 and `ad_out`=write data from T2 through T4; for reads `ad_oe`=0 from T2 through T4, and the word on `ad_in` at the edge that enters T4 is shown on `rd_data` while `done` is high.
- R7: `den_n` is driven from the falling clock edge: low from the middle of T2 to the middle of T4 (held through Tw), high otherwise; it stays high for halt cycles.
- R8: `dt_r` is 1 from T1 through T4 of a write cycle and 0 at all other times.
- R9: Status codes: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch, 101 memory read, 110 memory write, 111 passive. The code shows in the accepting ST_IDLE/ST_T4 cycle, in T1 and in T2, and is 111 in T3 and Tw.
- R10: A word request with address bit 0 = 1 is consumed with `req_err`=1 and `req_accept`=1, runs no T1, and leaves status passive.
- R11: When a request is pending in T4, T1 of the next cycle follows immediately with no idle state.
- R12: `req_kind` encoding: 0 data, 1 code fetch, 2 interrupt acknowledge, 3 halt. `req_write` is ignored for kinds 1 to 3 (cycle runs as a read, `dt_r`=0); a halt cycle drives no data (`ad_oe`=0 after T1) and captures none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request pending |
| req_addr | input | 20 | Physical address |
| req_write | input | 1 | 1 = write (data kind only) |
| req_io | input | 1 | 1 = I/O space |
| req_word | input | 1 | 1 = 16-bit access |
| req_kind | input | 2 | Cycle kind (R12) |
| req_seg | input | 2 | Segment tag shown in status |
| req_wdata | input | 16 | Write data, lane-positioned |
| req_accept | output | 1 | Request consumed this cycle |
| req_err | output | 1 | Request refused as misaligned |
| int_en | input | 1 | Interrupt-enable flag for status |
| ready | input | 1 | Wait control, sampled in T3/Tw |
| ad_in | input | 16 | Shared low lines, receive side |
| ad_out | output | 16 | Shared low lines, drive side |
| ad_oe | output | 1 | Drive enable for shared low lines |
| as_out | output | 4 | Upper shared lines: address or status |
| ale | output | 1 | Address latch strobe |
| bhe_n | output | 1 | Upper byte enable, active low |
| den_n | output | 1 | Data enable, active low |
| dt_r | output | 1 | 1 transmit, 0 receive |
| stat | output | 3 | Cycle status code |
| done | output | 1 | Cycle completes (T4) |
| rd_data | output | 16 | Captured read word |

## Verification
The bound checker watches, on every clock, the single-cycle address strobe, that no cycle completes straight after T1, that the byte enable and data enable stay inactive during T1 or outside it, that T1 never shows the passive code, that refusal is a consumption without a following T1, and that reads leave the lines undriven at completion. Wait-state counting, the exact one-state-early status of a queued request, the half-cycle data-enable edges, the captured read word, the ignored write bit for non-data kinds and the back-to-back T4-to-T1 hand-over depend on stimulus history and are shown by the bench's reference model over its scenarios.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
package mbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } bus_state_e;

    typedef enum logic [1:0] {
        KIND_DATA = 2'd0,
        KIND_CODE = 2'd1,
        KIND_INTA = 2'd2,
        KIND_HALT = 2'd3
    } cyc_kind_e;

    localparam int SEG_W  = 2;
    localparam int KIND_W = 2;
    localparam int STAT_W = 3;

    localparam logic [STAT_W-1:0] STAT_INTA    = 3'b000;
    localparam logic [STAT_W-1:0] STAT_IO_RD   = 3'b001;
    localparam logic [STAT_W-1:0] STAT_IO_WR   = 3'b010;
    localparam logic [STAT_W-1:0] STAT_HALT    = 3'b011;
    localparam logic [STAT_W-1:0] STAT_CODE    = 3'b100;
    localparam logic [STAT_W-1:0] STAT_MEM_RD  = 3'b101;
    localparam logic [STAT_W-1:0] STAT_MEM_WR  = 3'b110;
    localparam logic [STAT_W-1:0] STAT_PASSIVE = 3'b111;

endpackage

// File: rtl/mbus_status_gen.sv
`timescale 1ns/1ps
module mbus_status_gen
    import mbus_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic              io,
    input  logic              write,
    output logic [STAT_W-1:0] code
);

    always_comb begin
        code = STAT_PASSIVE;
        unique case (cyc_kind_e'(kind))
            KIND_DATA: begin
                if (io) code = write ? STAT_IO_WR  : STAT_IO_RD;
                else    code = write ? STAT_MEM_WR : STAT_MEM_RD;
            end
            KIND_CODE: code = STAT_CODE;
            KIND_INTA: code = STAT_INTA;
            KIND_HALT: code = STAT_HALT;
            default:   code = STAT_PASSIVE;
        endcase
    end

endmodule

// File: rtl/mbus_seq_fsm.sv
`timescale 1ns/1ps
module mbus_seq_fsm
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_word,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output bus_state_e        state,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_write,
    output logic              cur_io,
    output logic              cur_word,
    output logic              cur_halt,
    output logic [KIND_W-1:0] cur_kind,
    output logic [SEG_W-1:0]  cur_seg,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              accept,
    output logic              take,
    output logic              reject
);

    bus_state_e state_nx;
    logic       can_accept;
    logic       misaligned;
    logic       capture;

    assign can_accept = (state == ST_IDLE) || (state == ST_T4);
    assign misaligned = req_word && req_addr[0];
    assign accept     = can_accept && req_valid;
    assign take       = accept && !misaligned;
    assign reject     = accept && misaligned;
    assign capture    = ((state == ST_T3) || (state == ST_TW)) && ready
                        && !cur_write && !cur_halt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = take ? ST_T1 : ST_IDLE;
            ST_T1:   state_nx = ST_T2;
            ST_T2:   state_nx = ST_T3;
            ST_T3:   state_nx = ready ? ST_T4 : ST_TW;
            ST_TW:   state_nx = ready ? ST_T4 : ST_TW;
            ST_T4:   state_nx = take ? ST_T1 : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_write <= 1'b0;
            cur_io    <= 1'b0;
            cur_word  <= 1'b0;
            cur_halt  <= 1'b0;
            cur_kind  <= KIND_W'(KIND_DATA);
            cur_seg   <= '0;
            cur_wdata <= '0;
        end else if (take) begin
            cur_addr  <= req_addr;
            cur_write <= req_write && (cyc_kind_e'(req_kind) == KIND_DATA);
            cur_io    <= req_io;
            cur_word  <= req_word;
            cur_halt  <= cyc_kind_e'(req_kind) == KIND_HALT;
            cur_kind  <= req_kind;
            cur_seg   <= req_seg;
            cur_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rd_data <= '0;
        else if (capture) rd_data <= ad_in;
    end

endmodule

// File: rtl/mbus_pin_drv.sv
`timescale 1ns/1ps
module mbus_pin_drv
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        state,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cur_write,
    input  logic              cur_io,
    input  logic              cur_word,
    input  logic              cur_halt,
    input  logic [SEG_W-1:0]  cur_seg,
    input  logic [DATA_W-1:0] cur_wdata,
    input  logic [STAT_W-1:0] cur_code,
    input  logic              pend_take,
    input  logic [STAT_W-1:0] pend_code,
    input  logic              int_en,
    output logic              ale,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] as_out,
    output logic              bhe_n,
    output logic              den_n,
    output logic              dt_r,
    output logic [STAT_W-1:0] stat,
    output logic              done
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic            hi_drive;
    logic            hi_addr;
    logic [HI_W-1:0] st_hi;
    logic            data_phase;

    assign st_hi = HI_W'({1'b0, int_en, cur_seg});

    always_comb begin
        ale      = 1'b0;
        ad_oe    = 1'b0;
        ad_out   = cur_wdata;
        bhe_n    = 1'b1;
        dt_r     = 1'b0;
        stat     = STAT_PASSIVE;
        done     = 1'b0;
        hi_drive = 1'b0;
        hi_addr  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                stat = pend_take ? pend_code : STAT_PASSIVE;
            end
            ST_T1: begin
                ale      = 1'b1;
                ad_oe    = 1'b1;
                ad_out   = cur_addr[DATA_W-1:0];
                bhe_n    = !(cur_word || cur_addr[0]);
                dt_r     = cur_write;
                stat     = cur_code;
                hi_drive = 1'b1;
                hi_addr  = 1'b1;
            end
            ST_T2: begin
                ad_oe    = cur_write;
                dt_r     = cur_write;
                stat     = cur_code;
                hi_drive = 1'b1;
            end
            ST_T3, ST_TW: begin
                ad_oe    = cur_write;
                dt_r     = cur_write;
                hi_drive = 1'b1;
            end
            ST_T4: begin
                ad_oe    = cur_write;
                dt_r     = cur_write;
                done     = 1'b1;
                hi_drive = 1'b1;
                stat     = pend_take ? pend_code : STAT_PASSIVE;
            end
            default: ;
        endcase
    end

    for (genvar gi = 0; gi < HI_W; gi++) begin : g_upper
        always_comb begin
            if (!hi_drive)    as_out[gi] = 1'b0;
            else if (hi_addr) as_out[gi] = cur_addr[DATA_W+gi] && !cur_io;
            else              as_out[gi] = st_hi[gi];
        end
    end

    assign data_phase = ((state == ST_T2) || (state == ST_T3) || (state == ST_TW))
                        && !cur_halt;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) den_n <= 1'b1;
        else        den_n <= !data_phase;
    end

endmodule

// File: rtl/mbus_cycle_seq.sv
`timescale 1ns/1ps
module mbus_cycle_seq
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_write,
    input  logic                     req_io,
    input  logic                     req_word,
    input  logic [1:0]               req_kind,
    input  logic [1:0]               req_seg,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_accept,
    output logic                     req_err,
    input  logic                     int_en,
    input  logic                     ready,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] as_out,
    output logic                     ale,
    output logic                     bhe_n,
    output logic                     den_n,
    output logic                     dt_r,
    output logic [2:0]               stat,
    output logic                     done,
    output logic [DATA_W-1:0]        rd_data
);

    bus_state_e        state;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_write;
    logic              cur_io;
    logic              cur_word;
    logic              cur_halt;
    logic [KIND_W-1:0] cur_kind;
    logic [SEG_W-1:0]  cur_seg;
    logic [DATA_W-1:0] cur_wdata;
    logic              take;
    logic [STAT_W-1:0] cur_code;
    logic [STAT_W-1:0] pend_code;

    mbus_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_io    (req_io),
        .req_word  (req_word),
        .req_kind  (req_kind),
        .req_seg   (req_seg),
        .req_wdata (req_wdata),
        .ready     (ready),
        .ad_in     (ad_in),
        .state     (state),
        .cur_addr  (cur_addr),
        .cur_write (cur_write),
        .cur_io    (cur_io),
        .cur_word  (cur_word),
        .cur_halt  (cur_halt),
        .cur_kind  (cur_kind),
        .cur_seg   (cur_seg),
        .cur_wdata (cur_wdata),
        .rd_data   (rd_data),
        .accept    (req_accept),
        .take      (take),
        .reject    (req_err)
    );

    mbus_status_gen u_stat_cur (
        .kind  (cur_kind),
        .io    (cur_io),
        .write (cur_write),
        .code  (cur_code)
    );

    mbus_status_gen u_stat_pend (
        .kind  (req_kind),
        .io    (req_io),
        .write (req_write),
        .code  (pend_code)
    );

    mbus_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .cur_addr  (cur_addr),
        .cur_write (cur_write),
        .cur_io    (cur_io),
        .cur_word  (cur_word),
        .cur_halt  (cur_halt),
        .cur_seg   (cur_seg),
        .cur_wdata (cur_wdata),
        .cur_code  (cur_code),
        .pend_take (take),
        .pend_code (pend_code),
        .int_en    (int_en),
        .ale       (ale),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .as_out    (as_out),
        .bhe_n     (bhe_n),
        .den_n     (den_n),
        .dt_r      (dt_r),
        .stat      (stat),
        .done      (done)
    );

endmodule

// File: rtl/mbus_cycle_seq_chk.sv
`timescale 1ns/1ps
module mbus_cycle_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_accept,
    input logic       req_err,
    input logic       ad_oe,
    input logic       ale,
    input logic       bhe_n,
    input logic       den_n,
    input logic       dt_r,
    input logic [2:0] stat,
    input logic       done
);

    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    a_r5_no_done_after_t1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !done);

    a_r1_ale_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ale, done}));

    a_r4_bhe_only_t1: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |-> bhe_n);

    a_r7_den_off_in_t1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> den_n);

    a_r9_t1_not_passive: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (stat != 3'b111));

    a_r10_err_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_accept);

    a_r10_err_no_t1: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !ale);

    a_r6_read_float: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dt_r) |-> !ad_oe);

endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_accept (req_accept),
    .req_err    (req_err),
    .ad_oe      (ad_oe),
    .ale        (ale),
    .bhe_n      (bhe_n),
    .den_n      (den_n),
    .dt_r       (dt_r),
    .stat       (stat),
    .done       (done)
);

// File: tb/mbus_cycle_seq_bench.sv
`timescale 1ns/1ps
module mbus_cycle_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic        req_word = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_seg = '0;
    logic [15:0] req_wdata = '0;
    logic        int_en = 1'b0;
    logic        ready = 1'b1;
    logic [15:0] ad_in = '0;
    logic        req_accept, req_err, ad_oe, ale, bhe_n, den_n, dt_r, done;
    logic [15:0] ad_out, rd_data;
    logic [3:0]  as_out;
    logic [2:0]  stat;

    always #2 clk = ~clk;

    mbus_cycle_seq u_mbus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_io(req_io), .req_word(req_word),
        .req_kind(req_kind), .req_seg(req_seg), .req_wdata(req_wdata),
        .req_accept(req_accept), .req_err(req_err), .int_en(int_en),
        .ready(ready), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .as_out(as_out), .ale(ale), .bhe_n(bhe_n), .den_n(den_n),
        .dt_r(dt_r), .stat(stat), .done(done), .rd_data(rd_data)
    );

    typedef struct {
        logic [19:0] addr;
        logic        wr;
        logic        io;
        logic        word;
        logic [1:0]  kind;
        logic [1:0]  seg;
        logic [15:0] wdata;
        int          waits;
    } breq_t;

    breq_t q[$];
    breq_t m_cur;
    breq_t h;
    int    m_st = 0;   // 0 idle, 1 T1, 2 T2, 3 T3, 4 T4, 5 Tw
    int    m_wl = 0;
    int    b2b = 0;
    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    bit    finished = 0;

    function automatic breq_t mk(logic [19:0] a, logic w, logic io, logic wd,
                                 logic [1:0] k, logic [1:0] s, logic [15:0] d, int wt);
        breq_t r;
        r.addr = a; r.wr = w; r.io = io; r.word = wd;
        r.kind = k; r.seg = s; r.wdata = d; r.waits = wt;
        return r;
    endfunction

    function automatic logic [2:0] code_of(logic [1:0] k, logic io, logic wr);
        case (k)
            2'd0:    return io ? (wr ? 3'b010 : 3'b001) : (wr ? 3'b110 : 3'b101);
            2'd1:    return 3'b100;
            2'd2:    return 3'b000;
            default: return 3'b011;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: advances on each rising edge
    always @(posedge clk) begin
        if (!rst_n) m_st = 0;
        else begin
            case (m_st)
                0, 4: begin
                    if (req_valid && q.size() > 0) begin
                        h = q.pop_front();
                        if (h.word && h.addr[0]) m_st = 0;
                        else begin
                            if (m_st == 4) b2b++;
                            m_cur = h;
                            m_wl  = h.waits;
                            m_st  = 1;
                        end
                    end else m_st = 0;
                end
                1: m_st = 2;
                2: m_st = 3;
                3, 5: begin
                    if (ready) m_st = 4;
                    else begin m_wl--; m_st = 5; end
                end
                default: m_st = 0;
            endcase
        end
    end

    // input drive, half a nanosecond after the edge
    always @(posedge clk) begin
        #0.5;
        req_valid = (q.size() > 0);
        if (q.size() > 0) begin
            req_addr  = q[0].addr;  req_write = q[0].wr;
            req_io    = q[0].io;    req_word  = q[0].word;
            req_kind  = q[0].kind;  req_seg   = q[0].seg;
            req_wdata = q[0].wdata;
        end
        ready = !(((m_st == 3) || (m_st == 5)) && m_wl > 0);
        ad_in = (m_st >= 2) ? (m_cur.addr[15:0] ^ 16'h5A3C) : 16'hFFFF;
    end

    // output comparison, once per half-cycle
    always @(posedge clk) begin
        logic       wr_eff, halt, pend, e_err, e_acc;
        logic [2:0] e_stat;
        #1.5;
        if (rst_n && !finished) begin
            wr_eff = m_cur.wr && (m_cur.kind == 2'd0);
            halt   = (m_cur.kind == 2'd3);
            e_acc  = ((m_st == 0) || (m_st == 4)) && req_valid;
            e_err  = e_acc && req_word && req_addr[0];
            pend   = e_acc && !(req_word && req_addr[0]);
            chk("R2 ale", ale, m_st == 1);
            chk((m_st >= 1 && halt) ? "R12 ad_oe" : "R6 ad_oe", ad_oe,
                (m_st == 1) || (m_st >= 2 && wr_eff));
            if (m_st == 1) begin
                chk("R2 ad_out address", ad_out, m_cur.addr[15:0]);
                chk("R2 as_out address", as_out, m_cur.io ? 4'h0 : m_cur.addr[19:16]);
                chk("R4 bhe_n in T1", bhe_n, !(m_cur.word || m_cur.addr[0]));
            end else begin
                chk("R4 bhe_n outside T1", bhe_n, 1'b1);
                if (m_st >= 2) begin
                    chk("R3 as_out status", as_out, {1'b0, int_en, m_cur.seg});
                    if (wr_eff) chk("R6 write data", ad_out, m_cur.wdata);
                end else chk("R1 as_out idle", as_out, 4'h0);
            end
            chk((m_cur.kind != 2'd0 && m_st >= 1) ? "R12 dt_r" : "R8 dt_r",
                dt_r, (m_st >= 1) && wr_eff);
            if (m_st == 1 || m_st == 2) e_stat = code_of(m_cur.kind, m_cur.io, wr_eff);
            else if (m_st == 3 || m_st == 5) e_stat = 3'b111;
            else e_stat = pend ? code_of(req_kind, req_io, req_write && req_kind == 2'd0)
                               : 3'b111;
            chk("R9 stat", stat, e_stat);
            chk("R5 done", done, m_st == 4);
            chk("R10 req_err", req_err, e_err);
            chk("R10 req_accept", req_accept, e_acc);
            if (m_st == 4 && !wr_eff && !halt)
                chk("R6 rd_data", rd_data, m_cur.addr[15:0] ^ 16'h5A3C);
            chk("R7 den_n first half", den_n,
                !((m_st == 3 || m_st == 4 || m_st == 5) && !halt));
        end
        #2;
        if (rst_n && !finished) begin
            halt = (m_cur.kind == 2'd3);
            chk("R7 den_n second half", den_n,
                !((m_st == 2 || m_st == 3 || m_st == 5) && !halt));
        end
    end

    task automatic summary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !finished) begin
            checks++;
            failures++;
            $display("FAIL R5 watchdog actual=hung expected=completion");
            summary();
        end
    end

    task automatic push(input breq_t r);
        @(posedge clk);
        #0.2;
        q.push_back(r);
    endtask

    task automatic wait_idle();
        while (q.size() != 0 || m_st != 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #0.3 rst_n = 1'b1;
        @(posedge clk);
        #1.6;
        chk("R1 reset ale", ale, 1'b0);
        chk("R1 reset den_n", den_n, 1'b1);
        chk("R1 reset stat", stat, 3'b111);
        chk("R1 reset done", done, 1'b0);
        chk("R1 reset ad_oe", ad_oe, 1'b0);
        chk("R1 reset bhe_n", bhe_n, 1'b1);

        // memory word read, no waits
        push(mk(20'h12344, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1, 16'h0000, 0));
        wait_idle();
        // I/O byte write at odd address, two wait states, interrupts enabled
        @(posedge clk); #0.7 int_en = 1'b1;
        push(mk(20'hA0081, 1'b1, 1'b1, 1'b0, 2'd0, 2'd3, 16'hBE00, 2));
        wait_idle();
        // code fetch with stray write bit, one wait state
        push(mk(20'hFFFF0, 1'b1, 1'b0, 1'b1, 2'd1, 2'd2, 16'hDEAD, 1));
        wait_idle();
        // halt cycle
        push(mk(20'h00000, 1'b0, 1'b0, 1'b0, 2'd3, 2'd0, 16'h0000, 0));
        wait_idle();
        // misaligned word is refused
        push(mk(20'h00123, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1, 16'h0000, 0));
        wait_idle();
        // three back-to-back cycles with the flag changing mid-way
        @(posedge clk);
        #0.2;
        q.push_back(mk(20'h54320, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 16'h0000, 0));
        q.push_back(mk(20'h00000, 1'b0, 1'b0, 1'b1, 2'd2, 2'd0, 16'h0000, 0));
        q.push_back(mk(20'h00100, 1'b1, 1'b0, 1'b1, 2'd0, 2'd3, 16'h1234, 3));
        repeat (5) @(posedge clk);
        #0.7 int_en = 1'b0;
        wait_idle();
        chk("R11 back-to-back T4->T1 count", b2b, 2);
        summary();
    end

endmodule